// File: doc/BRIEF.md
# Serial Line Front-End Register File with Static-Word Shifter

This block sits on a simple CPU register port and gives software two ways to reach a slow serial link into an always-on clock domain. In the first way, software drives the link by hand. It writes three line bits that appear directly on the serial clock, enable and data-in pins. It reads back the data-out line and a ready flag from a status word. Reading the data-out line after each clock pulse gives it the bits that come back.

The second way is a one-shot hardware shifter for a 16-bit static configuration word. Software first writes the upper byte to its own register. It then writes the control word with the lower byte and the start bit set. The shifter latches both bytes and raises a busy flag. It then takes over the clock and data-in pins and shifts the word out most significant bit first. Each bit gets a clock low phase and a clock high phase, and each phase lasts `DIV_HALF` cycles. When the shifter finishes, it hands the pins back to the software line bits. The reset value of the stored bytes is the default configuration word 0x180A.

Top module: `serfe_top`

## Requirements
- R1: After reset, all three serial pins are low. A read of offset 0x00 returns 0x0A000000 and a read of offset 0x10 returns 0x00000018.
- R2: While the shifter is idle, a write to offset 0x00 drives its bit 0 onto `ser_clk_o`, bit 1 onto `ser_en_o` and bit 2 onto `ser_din_o`, starting the cycle after the write edge.
- R3: A read of offset 0x04 returns `ser_dout_i` in bit 0 and `ser_ready_i` in bit 1, with all other bits zero. Writes to offset 0x04 have no effect.
- R4: Offset 0x10 stores the upper byte of the static word in bits 7:0, and its other bits read as zero. Offsets 0x08 and 0x0C always read as zero and ignore writes.
- R5: A write to offset 0x00 with bit 17 set while the shifter is idle latches the word {offset 0x10 bits 7:0, write data bits 31:24}. Busy (bit 22 of offset 0x00) is then high from the next cycle. Bit 17 always reads as 0, and bits 31:24 read back the last value written.
- R6: The shifter sends the latched word most significant bit first, as 16 rising clock edges spaced 2*`DIV_HALF` cycles apart. The clock starts low, and data-in is stable at every rising edge.
- R7: Busy stays high for exactly 32*`DIV_HALF` cycles. After that, the pins show the software line bits again.
- R8: A start write made while busy does not restart, extend or change the transfer in progress.
- R9: Writes to bits 2:0 of offset 0x00 made while busy are dropped: the line bits keep their old value, and `ser_en_o` does not change.
- R10: Address bits 1:0 are ignored when decoding which register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ser_clk_o | output | 1 | Serial clock toward the clock domain |
| ser_en_o | output | 1 | Serial enable toward the clock domain |
| ser_din_o | output | 1 | Serial data toward the clock domain |
| ser_dout_i | input | 1 | Serial data returned by the clock domain |
| ser_ready_i | input | 1 | Ready flag from the clock domain |

## Verification
A read request is captured at one clock edge, and its data is checked on the falling edge that follows. Every line-bit write shows up on the pins exactly one edge after it is captured. The first status read issued straight after a start write already sees busy. Back-to-back reads then see busy set for exactly 32*`DIV_HALF` consecutive edges, so counting those reads measures the busy length to the cycle. A falling-edge monitor pops one expected data bit from a scoreboard queue at every rising serial clock and records the cycle of each rise. The bench then checks that the rises are 2*`DIV_HALF` cycles apart and that no rise is left over after a transfer ends.

// File: rtl/serfe_pkg.sv
package serfe_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // word indices (byte offset / 4)
  localparam int IDX_CTL   = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_RSV0  = 2;
  localparam int IDX_RSV1  = 3;
  localparam int IDX_UPPER = 4;

  // control word fields
  localparam int CTL_CLK_BIT  = 0;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_DIN_BIT  = 2;
  localparam int CTL_GO_BIT   = 17;
  localparam int CTL_BUSY_BIT = 22;
  localparam int CTL_LO_LSB   = 24;

  function automatic logic [DATA_W-1:0] ctl_word(input logic [2:0] lines,
                                                 input logic busy,
                                                 input logic [BYTE_W-1:0] lo);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTL_CLK_BIT] = lines[0];
    w[CTL_EN_BIT]  = lines[1];
    w[CTL_DIN_BIT] = lines[2];
    w[CTL_BUSY_BIT] = busy;
    w[CTL_LO_LSB +: BYTE_W] = lo;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(input logic dout, input logic ready);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = dout;
    w[1] = ready;
    return w;
  endfunction

  // length of one complete transfer in clock cycles
  function automatic int serial_cycles(input int half, input int nbits);
    return 2 * half * nbits;
  endfunction

endpackage

// File: rtl/serfe_regs.sv
module serfe_regs
  import serfe_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] STATIC_RST = 16'h180A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy_i,
  input  logic              dout_i,
  input  logic              ready_i,
  output logic [2:0]        line_o,
  output logic              start_o,
  output logic [15:0]       payload_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic wr, rd, hit_ctl, hit_stat, hit_upper;
  logic [2:0]        line_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  assign word      = bus_addr[ADDR_W-1:2];
  assign wr        = bus_sel & bus_we;
  assign rd        = bus_sel & ~bus_we;
  assign hit_ctl   = (word == WORD_W'(IDX_CTL));
  assign hit_stat  = (word == WORD_W'(IDX_STAT));
  assign hit_upper = (word == WORD_W'(IDX_UPPER));

  assign start_o   = wr & hit_ctl & bus_wdata[CTL_GO_BIT] & ~busy_i;
  assign payload_o = {hi_q, bus_wdata[CTL_LO_LSB +: BYTE_W]};

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)        rd_mux = ctl_word(line_q, busy_i, lo_q);
    else if (hit_stat)  rd_mux = stat_word(dout_i, ready_i);
    else if (hit_upper) rd_mux = {{(DATA_W-BYTE_W){1'b0}}, hi_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      lo_q    <= STATIC_RST[BYTE_W-1:0];
      hi_q    <= STATIC_RST[2*BYTE_W-1:BYTE_W];
      rdata_q <= '0;
    end else begin
      if (wr && hit_ctl) begin
        lo_q <= bus_wdata[CTL_LO_LSB +: BYTE_W];
        if (!busy_i) line_q <= bus_wdata[2:0];
      end
      if (wr && hit_upper) hi_q <= bus_wdata[BYTE_W-1:0];
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign line_o    = line_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/serfe_shift.sv
module serfe_shift #(
  parameter int PAY_W    = 16,
  parameter int DIV_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PAY_W-1:0] payload_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             sdin_o,
  output logic             step_o,
  output logic             done_o
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int IDX_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;
  localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(DIV_HALF - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(PAY_W - 1);

  logic             busy_q, phase_q, half_end;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] idx_q;
  logic [PAY_W-1:0] sh_q;

  assign half_end = busy_q & (div_q == LAST_DIV);
  assign step_o   = half_end & phase_q;
  assign done_o   = step_o & (idx_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      div_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      div_q   <= '0;
      idx_q   <= '0;
      sh_q    <= payload_i;
    end else if (busy_q) begin
      if (half_end) begin
        div_q   <= '0;
        phase_q <= ~phase_q;
        if (phase_q) begin
          sh_q <= {sh_q[PAY_W-2:0], 1'b0};
          if (done_o) busy_q <= 1'b0;
          else        idx_q  <= idx_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = busy_q & phase_q;
  assign sdin_o = sh_q[PAY_W-1];

endmodule

// File: rtl/serfe_pinmux.sv
module serfe_pinmux (
  input  logic       busy_i,
  input  logic [2:0] line_i,
  input  logic       sclk_i,
  input  logic       sdin_i,
  output logic       ser_clk_o,
  output logic       ser_en_o,
  output logic       ser_din_o
);

  always_comb begin
    ser_en_o = line_i[1];
    if (busy_i) begin
      ser_clk_o = sclk_i;
      ser_din_o = sdin_i;
    end else begin
      ser_clk_o = line_i[0];
      ser_din_o = line_i[2];
    end
  end

endmodule

// File: rtl/serfe_top.sv
module serfe_top #(
  parameter int          ADDR_W     = 8,
  parameter int          DIV_HALF   = 4,
  parameter logic [15:0] STATIC_RST = 16'h180A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ser_clk_o,
  output logic              ser_en_o,
  output logic              ser_din_o,
  input  logic              ser_dout_i,
  input  logic              ser_ready_i
);

  logic [2:0]  line;
  logic        start;
  logic [15:0] payload;
  logic        shift_busy, shift_clk, shift_din, shift_step, shift_done;

  serfe_regs #(.ADDR_W(ADDR_W), .STATIC_RST(STATIC_RST)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(shift_busy), .dout_i(ser_dout_i), .ready_i(ser_ready_i),
    .line_o(line), .start_o(start), .payload_o(payload)
  );

  serfe_shift #(.PAY_W(16), .DIV_HALF(DIV_HALF)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .payload_i(payload),
    .busy_o(shift_busy), .sclk_o(shift_clk), .sdin_o(shift_din),
    .step_o(shift_step), .done_o(shift_done)
  );

  serfe_pinmux mux_i (
    .busy_i(shift_busy), .line_i(line),
    .sclk_i(shift_clk), .sdin_i(shift_din),
    .ser_clk_o(ser_clk_o), .ser_en_o(ser_en_o), .ser_din_o(ser_din_o)
  );

endmodule

// File: rtl/serfe_chk.sv
module serfe_chk
  import serfe_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       step,
  input logic       done,
  input logic [2:0] line,
  input logic       sclk_pin,
  input logic       sdin_pin,
  input logic       en_pin
);

  localparam int TOTAL = serial_cycles(DIV_HALF, 16);

  logic [31:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_cnt <= '0;
    else if (start) run_cnt <= '0;
    else if (busy)  run_cnt <= run_cnt + 1'b1;
  end

  // R5
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R6
  clock_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk_pin);

  // R6
  din_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(sclk_pin)) |-> $stable(sdin_pin));

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 32'(TOTAL - 1)));

  // R7
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R9
  line_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(line) && $stable(en_pin)));

  // R6
  step_in_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> sclk_pin);

endmodule

bind serfe_top serfe_chk #(.DIV_HALF(DIV_HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(shift_busy),
  .step(shift_step), .done(shift_done), .line(line),
  .sclk_pin(ser_clk_o), .sdin_pin(ser_din_o), .en_pin(ser_en_o)
);

// File: tb/serfe_top_tb_top.sv
module serfe_top_tb_top;

  localparam int H     = 4;
  localparam int WD_NS = 150000 * 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ser_clk_o, ser_en_o, ser_din_o;
  logic ser_dout_i = 1'b0, ser_ready_i = 1'b0;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  logic exp_q[$];
  int   rise_q[$];
  logic mon_prev = 1'b0;

  always #10 clk = ~clk;

  serfe_top #(.ADDR_W(8), .DIV_HALF(H), .STATIC_RST(16'h180A)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk_o(ser_clk_o), .ser_en_o(ser_en_o), .ser_din_o(ser_din_o),
    .ser_dout_i(ser_dout_i), .ser_ready_i(ser_ready_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: one scoreboard item per rising serial clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !mon_prev && ser_clk_o) begin
      rise_q.push_back(cyc);
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual unexpected clock rise (din %0b) expected no rise", ser_din_o);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (ser_din_o !== e) begin
          errors++;
          $display("FAIL R6: actual din %0b expected %0b", ser_din_o, e);
        end
      end
    end
    mon_prev = ser_clk_o;
  end

  // called on a falling edge; returns on the next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_word(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) exp_q.push_back(v[i]);
  endtask

  task automatic poll_idle(output int n);
    logic [31:0] d;
    n = 0;
    forever begin
      bus_read(8'h00, d);
      if (!d[22]) break;
      n++;
    end
  endtask

  initial begin
    #(WD_NS);
    errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h0);
    bus_read(8'h00, d); chk("R1 ctl", d, 32'h0A000000);
    bus_read(8'h10, d); chk("R1 upper", d, 32'h00000018);

    // R3 status mirrors inputs, writes ignored
    ser_dout_i = 1'b1; ser_ready_i = 1'b0;
    bus_read(8'h04, d); chk("R3 dout", d, 32'h1);
    ser_dout_i = 1'b0; ser_ready_i = 1'b1;
    bus_read(8'h04, d); chk("R3 ready", d, 32'h2);
    bus_write(8'h04, 32'hFFFFFFFF);
    bus_read(8'h04, d); chk("R3 write ignored", d, 32'h2);

    // R4 spare words and upper byte
    bus_write(8'h08, 32'hFFFFFFFF);
    bus_write(8'h0C, 32'hFFFFFFFF);
    bus_read(8'h08, d); chk("R4 spare0", d, 32'h0);
    bus_read(8'h0C, d); chk("R4 spare1", d, 32'h0);
    bus_write(8'h10, 32'hFFFFFF77);
    bus_read(8'h10, d); chk("R4 upper byte", d, 32'h77);

    // R10 low address bits ignored
    bus_write(8'h13, 32'h0000005A);
    bus_read(8'h11, d); chk("R10 upper alias", d, 32'h5A);
    bus_read(8'h03, d); chk("R10 ctl alias", d, 32'h0A000000);

    // R2 software line control, one pulse each of 0 and 1
    bus_write(8'h00, 32'h0A000006);
    chk("R2 pins en+din", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h6);
    exp_q.push_back(1'b1);
    bus_write(8'h00, 32'h0A000007);
    chk("R2 pins clk high", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h7);
    bus_write(8'h00, 32'h0A000002);
    exp_q.push_back(1'b0);
    bus_write(8'h00, 32'h0A000003);
    chk("R2 pins din low", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h3);
    bus_write(8'h00, 32'h0A000002);
    repeat (2) @(negedge clk);
    chk("R2 bitbang bits consumed", exp_q.size(), 0);

    // R5/R6/R7 transfer of 0x3CA5
    bus_write(8'h10, 32'h0000003C);
    push_word(16'h3CA5);
    rise_q.delete();
    bus_write(8'h00, 32'hA5020002);
    bus_read(8'h00, d); chk("R5 busy and low byte", d, 32'hA5400002);
    poll_idle(n);
    chk("R7 busy length", n + 1, 32 * H);
    chk("R6 rise count", rise_q.size(), 16);
    bad = 0;
    for (int i = 1; i < rise_q.size(); i++)
      if (rise_q[i] - rise_q[i-1] != 2 * H) bad++;
    chk("R6 rise spacing", bad, 0);
    chk("R6 all bits sent", exp_q.size(), 0);
    chk("R7 pins returned", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h2);

    // R9 line writes during busy dropped
    bus_write(8'h10, 32'h00000018);
    push_word(16'h180A);
    bus_write(8'h00, 32'h0A020002);
    bus_write(8'h00, 32'h0A000005);
    chk("R9 en held", {31'b0, ser_en_o}, 32'h1);
    poll_idle(n);
    chk("R9 pins after", {29'b0, ser_din_o, ser_en_o, ser_clk_o}, 32'h2);
    bus_read(8'h00, d); chk("R9 lines kept", d, 32'h0A000002);
    chk("R9 transfer intact", exp_q.size(), 0);

    // R8 restart while busy ignored
    push_word(16'h180A);
    bus_write(8'h00, 32'h0A020002);
    for (int i = 0; i < 10; i++) bus_read(8'h00, d);
    bus_write(8'h00, 32'hFF020002);
    poll_idle(n);
    chk("R8 busy not extended", 11 + n, 32 * H);
    repeat (40) @(negedge clk);
    chk("R8 no extra bits", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule